// File: doc/BRIEF.md
# Dual-Mask Level Interrupt Controller

This block gathers up to 32 level-sensitive interrupt request lines. The default build uses the low 22 of them. It combines the lines into two processor request outputs: a normal request and a fast request. Each output has its own enable mask. Software never writes a mask directly. It writes a one to a bit of a set register to enable that source for one path, or a one to a bit of a clear register to disable it. A bit left at zero in either register leaves that source's enable as it was, so one driver can change its own source without a read-modify-write race against another driver.

Software reads the registers through a simple single-cycle bus. The read-back values are:
- the line levels (raw status);
- each path's masked status;
- each path's current enable mask.

A saved mask can be restored by writing it to the set register after a full clear. Both request outputs are registered.

Top module: `intc_dual_mask`

## Requirements
- R1: After reset both enable masks are zero, and `irq_o` and `fiq_o` are low.
- R2: A write to offset 0x08 enables, for the normal path, every source whose bit in the written word is 1. Sources whose bit is 0 keep their enable. The new mask is readable at offset 0x08 on the next cycle.
- R3: A write to offset 0x0C disables, for the normal path, every source whose bit is 1. Writing all ones leaves the normal mask at zero.
- R4: Offsets 0x28 (set) and 0x2C (clear) act on the fast-path mask in the same way, and the fast mask is readable at 0x28. Writes to the fast-path registers leave the normal mask unchanged, and writes to the normal-path registers leave the fast mask unchanged.
- R5: Only the sources in `VALID_MASK` (default 0x003FFFFF, bits 21:0) can be enabled. Enable bits outside it always read as 0.
- R6: `irq_o` is 1 exactly when some source is high and enabled for the normal path. It changes one clock edge after the source level or the mask changes.
- R7: `fiq_o` follows the same rule using the fast mask, with the same one-edge delay.
- R8: Reads return values combinationally in the same cycle, as follows:
  - 0x00 returns the normal masked status (line AND normal enable).
  - 0x04 returns the raw line levels restricted to `VALID_MASK`.
  - 0x20 returns the fast masked status.
  - 0x08 and 0x28 return the masks.
  - Every other offset, including 0x0C and 0x2C, reads 0.
- R9: Writes to offsets that are not set or clear registers (for example 0x00 and 0x04) change neither mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Level-sensitive interrupt lines, active high |
| sel_i | input | 1 | Bus access strobe for this cycle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | NUM_SRC | Write data |
| rdata_o | output | NUM_SRC | Read data, valid in the same cycle as the strobe |
| irq_o | output | 1 | Normal interrupt request, registered |
| fiq_o | output | 1 | Fast interrupt request, registered |

## Verification
Read data is combinational, so every read is sampled in the same cycle as its strobe. A mask write takes effect at the edge that accepts it, so the next read already shows the new mask. The request outputs need one more edge after that, and also one edge after a line changes.

The bench drives on falling edges and checks each output on the falling edge where it is due. Where a delay matters, it also checks on the falling edge just before, to confirm the output has not moved early. The tests cover:
- the partial-word set;
- the all-ones clear;
- cross-path isolation;
- out-of-range enable bits;
- ignored writes.

// File: rtl/intc_pkg.sv
package intc_pkg;
    // byte offsets of the register map
    localparam logic [7:0] OFF_IRQ_STAT = 8'h00;
    localparam logic [7:0] OFF_RAW_STAT = 8'h04;
    localparam logic [7:0] OFF_IRQ_SET  = 8'h08;
    localparam logic [7:0] OFF_IRQ_CLR  = 8'h0C;
    localparam logic [7:0] OFF_FIQ_STAT = 8'h20;
    localparam logic [7:0] OFF_FIQ_SET  = 8'h28;
    localparam logic [7:0] OFF_FIQ_CLR  = 8'h2C;

    localparam int unsigned NUM_PATHS = 2;
    localparam int unsigned PATH_IRQ  = 0;
    localparam int unsigned PATH_FIQ  = 1;

    typedef struct packed {
        logic irq;
        logic fiq;
    } req_t;
endpackage

// File: rtl/intc_enable_bank.sv
module intc_enable_bank #(
    parameter int unsigned         NUM_SRC    = 32,
    parameter logic [NUM_SRC-1:0]  VALID_MASK = 32'h003F_FFFF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_stb,
    input  logic               clr_stb,
    input  logic [NUM_SRC-1:0] wdata,
    output logic [NUM_SRC-1:0] en_q
);
    logic [NUM_SRC-1:0] en_d;
    logic [NUM_SRC-1:0] set_bits;
    logic [NUM_SRC-1:0] clr_bits;

    always_comb begin
        set_bits = set_stb ? wdata : '0;
        clr_bits = clr_stb ? wdata : '0;
        en_d     = ((en_q | set_bits) & ~clr_bits) & VALID_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end
endmodule

// File: rtl/intc_req_stage.sv
module intc_req_stage
    import intc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] lines,
    input  logic [NUM_SRC-1:0] irq_en,
    input  logic [NUM_SRC-1:0] fiq_en,
    output req_t               req_q
);
    req_t req_d;

    always_comb begin
        req_d.irq = |(lines & irq_en);
        req_d.fiq = |(lines & fiq_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_d;
    end
endmodule

// File: rtl/intc_dual_mask.sv
module intc_dual_mask
    import intc_pkg::*;
#(
    parameter int unsigned        NUM_SRC    = 32,
    parameter int unsigned        ADDR_W     = 8,
    parameter logic [NUM_SRC-1:0] VALID_MASK = 32'h003F_FFFF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               sel_i,
    input  logic               wr_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    output logic [NUM_SRC-1:0] rdata_o,
    output logic               irq_o,
    output logic               fiq_o
);
    localparam logic [NUM_PATHS*8-1:0] SET_OFFS = {OFF_FIQ_SET, OFF_IRQ_SET};
    localparam logic [NUM_PATHS*8-1:0] CLR_OFFS = {OFF_FIQ_CLR, OFF_IRQ_CLR};

    logic [NUM_SRC-1:0] lines;
    logic [NUM_SRC-1:0] en_q [NUM_PATHS];
    logic [NUM_SRC-1:0] irq_en_q;
    logic [NUM_SRC-1:0] fiq_en_q;
    logic               wr_stb;
    logic               rd_stb;
    req_t               req_q;

    assign lines  = src_i & VALID_MASK;
    assign wr_stb = sel_i & wr_i;
    assign rd_stb = sel_i & ~wr_i;

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
        logic set_stb;
        logic clr_stb;
        assign set_stb = wr_stb && (addr_i == ADDR_W'(SET_OFFS[p*8 +: 8]));
        assign clr_stb = wr_stb && (addr_i == ADDR_W'(CLR_OFFS[p*8 +: 8]));

        intc_enable_bank #(
            .NUM_SRC    (NUM_SRC),
            .VALID_MASK (VALID_MASK)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_stb (set_stb),
            .clr_stb (clr_stb),
            .wdata   (wdata_i),
            .en_q    (en_q[p])
        );
    end

    assign irq_en_q = en_q[PATH_IRQ];
    assign fiq_en_q = en_q[PATH_FIQ];

    intc_req_stage #(
        .NUM_SRC (NUM_SRC)
    ) u_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .lines  (lines),
        .irq_en (irq_en_q),
        .fiq_en (fiq_en_q),
        .req_q  (req_q)
    );

    assign irq_o = req_q.irq;
    assign fiq_o = req_q.fiq;

    always_comb begin
        rdata_o = '0;
        if (rd_stb) begin
            if      (addr_i == ADDR_W'(OFF_IRQ_STAT)) rdata_o = lines & irq_en_q;
            else if (addr_i == ADDR_W'(OFF_RAW_STAT)) rdata_o = lines;
            else if (addr_i == ADDR_W'(OFF_IRQ_SET))  rdata_o = irq_en_q;
            else if (addr_i == ADDR_W'(OFF_FIQ_STAT)) rdata_o = lines & fiq_en_q;
            else if (addr_i == ADDR_W'(OFF_FIQ_SET))  rdata_o = fiq_en_q;
        end
    end
endmodule

// File: rtl/intc_dual_mask_chk.sv
module intc_dual_mask_chk
    import intc_pkg::*;
#(
    parameter int unsigned        NUM_SRC    = 32,
    parameter int unsigned        ADDR_W     = 8,
    parameter logic [NUM_SRC-1:0] VALID_MASK = 32'h003F_FFFF
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_i,
    input logic               sel_i,
    input logic               wr_i,
    input logic [ADDR_W-1:0]  addr_i,
    input logic [NUM_SRC-1:0] wdata_i,
    input logic               irq_o,
    input logic               fiq_o,
    input logic [NUM_SRC-1:0] irq_en_q,
    input logic [NUM_SRC-1:0] fiq_en_q
);
    logic irq_set_w, irq_clr_w, fiq_set_w, fiq_clr_w;
    assign irq_set_w = sel_i && wr_i && addr_i == ADDR_W'(OFF_IRQ_SET);
    assign irq_clr_w = sel_i && wr_i && addr_i == ADDR_W'(OFF_IRQ_CLR);
    assign fiq_set_w = sel_i && wr_i && addr_i == ADDR_W'(OFF_FIQ_SET);
    assign fiq_clr_w = sel_i && wr_i && addr_i == ADDR_W'(OFF_FIQ_CLR);

    // R2
    irq_set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set_w |=> ((irq_en_q & $past(wdata_i) & VALID_MASK) == ($past(wdata_i) & VALID_MASK)));

    // R3
    irq_clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr_w |=> ((irq_en_q & $past(wdata_i)) == '0));

    // R4
    fiq_wr_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fiq_set_w || fiq_clr_w) |=> $stable(irq_en_q));

    // R4
    irq_wr_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_set_w || irq_clr_w) |=> $stable(fiq_en_q));

    // R5
    no_invalid_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_en_q | fiq_en_q) & ~VALID_MASK) == '0);

    // R6
    irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == |($past(src_i) & $past(irq_en_q))));

    // R7
    fiq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (fiq_o == |($past(src_i) & $past(fiq_en_q))));
endmodule

bind intc_dual_mask intc_dual_mask_chk #(
    .NUM_SRC    (NUM_SRC),
    .ADDR_W     (ADDR_W),
    .VALID_MASK (VALID_MASK)
) u_chk (.*);

// File: tb/intc_dual_mask_test.sv
`timescale 1ns/1ps
module intc_dual_mask_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fiq;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    intc_dual_mask uut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .sel_i(sel), .wr_i(wr),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at a falling edge, returns at the next falling edge (write accepted)
    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; wdata = '0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        sel = 1'b1; wr = 1'b0; addr = a;
        #0.5;
        d = rdata;
        sel = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        src = 32'hFFFF_FFFF;
        @(negedge clk);
        check("R1 irq_o after reset", {31'b0, irq}, 32'h0);
        check("R1 fiq_o after reset", {31'b0, fiq}, 32'h0);
        rd_reg(8'h08, v); check("R1 irq mask reset", v, 32'h0);
        rd_reg(8'h28, v); check("R1 fiq mask reset", v, 32'h0);
        src = '0;
        @(negedge clk);
    endtask

    task automatic t_irq_set();
        logic [31:0] v;
        src = 32'h0000_00F0;
        wr_reg(8'h08, 32'h0000_0011);
        rd_reg(8'h08, v); check("R2 set mask", v, 32'h0000_0011);
        check("R6 irq_o not yet", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check("R6 irq_o one edge later", {31'b0, irq}, 32'h1);
        wr_reg(8'h08, 32'h0000_0100);
        rd_reg(8'h08, v); check("R2 zero bits keep enables", v, 32'h0000_0111);
        rd_reg(8'h00, v); check("R8 irq masked status", v, 32'h0000_0010);
        src = 32'h0000_00E0;
        @(negedge clk);
        check("R6 irq_o falls after line drops", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_valid();
        logic [31:0] v;
        wr_reg(8'h08, 32'hFFFF_FFFF);
        rd_reg(8'h08, v); check("R5 irq mask limited", v, 32'h003F_FFFF);
        src = 32'hFFC0_0000;
        @(negedge clk); @(negedge clk);
        check("R5 invalid line cannot request", {31'b0, irq}, 32'h0);
        src = '0;
    endtask

    task automatic t_clear();
        logic [31:0] v;
        src = 32'h0000_0001;
        @(negedge clk); @(negedge clk);
        check("R6 irq_o high before clear", {31'b0, irq}, 32'h1);
        wr_reg(8'h0C, 32'h0000_0001);
        rd_reg(8'h08, v); check("R3 single clear", v, 32'h003F_FFFE);
        check("R6 irq_o still high", {31'b0, irq}, 32'h1);
        @(negedge clk);
        check("R6 irq_o low after clear", {31'b0, irq}, 32'h0);
        wr_reg(8'h0C, 32'hFFFF_FFFF);
        rd_reg(8'h08, v); check("R3 clear all", v, 32'h0);
        src = '0;
    endtask

    task automatic t_fiq();
        logic [31:0] v;
        wr_reg(8'h08, 32'h0000_0003);
        wr_reg(8'h28, 32'h0000_0F00);
        rd_reg(8'h28, v); check("R4 fiq set", v, 32'h0000_0F00);
        rd_reg(8'h08, v); check("R4 irq mask untouched by fiq set", v, 32'h0000_0003);
        src = 32'h0000_0200;
        @(negedge clk);
        check("R7 fiq_o one edge later", {31'b0, fiq}, 32'h1);
        check("R6 irq_o stays low", {31'b0, irq}, 32'h0);
        rd_reg(8'h20, v); check("R8 fiq masked status", v, 32'h0000_0200);
        rd_reg(8'h00, v); check("R8 irq masked status zero", v, 32'h0);
        wr_reg(8'h2C, 32'h0000_0200);
        rd_reg(8'h28, v); check("R4 fiq clear", v, 32'h0000_0D00);
        rd_reg(8'h08, v); check("R4 irq mask untouched by fiq clear", v, 32'h0000_0003);
        @(negedge clk);
        check("R7 fiq_o low after clear", {31'b0, fiq}, 32'h0);
        wr_reg(8'h0C, 32'h0000_0003);
        rd_reg(8'h28, v); check("R4 fiq mask untouched by irq clear", v, 32'h0000_0D00);
        src = 32'hFFFF_FFFF;
        @(negedge clk);
        rd_reg(8'h04, v); check("R8 raw status limited", v, 32'h003F_FFFF);
        src = '0;
    endtask

    task automatic t_ignored();
        logic [31:0] v;
        wr_reg(8'h00, 32'hFFFF_FFFF);
        wr_reg(8'h04, 32'hFFFF_FFFF);
        wr_reg(8'h20, 32'hFFFF_FFFF);
        rd_reg(8'h08, v); check("R9 irq mask unchanged", v, 32'h0);
        rd_reg(8'h28, v); check("R9 fiq mask unchanged", v, 32'h0000_0D00);
        rd_reg(8'h0C, v); check("R8 clear register reads zero", v, 32'h0);
        rd_reg(8'h10, v); check("R8 unmapped reads zero", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_irq_set();
        t_valid();
        t_clear();
        t_fiq();
        t_ignored();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog: actual=timeout expected=finish");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule